// File: doc/BRIEF.md
# Bus access watchpoint unit

This block watches the stream of memory accesses granted by a memory arbiter. It holds four independent watchpoints. Each has an address window, a mask of requesting clients and a mask of access kinds. When an access lands inside a window and both masks accept it, that watchpoint records the details of the access. It then raises a sticky status bit, which software reads and acknowledges through a small word-addressed register port.

The first qualifying access after a watchpoint is armed fills its record: address, access kind, client ID and size. Later qualifying accesses only add their client bit to an accumulated client set. The record stays as it is until software rearms that watchpoint. The four status bits are gated by a per-watchpoint enable, and the enabled bits are merged into a single interrupt line. Status bits are cleared by writing ones to a global acknowledge register.

Register map (word index on `reg_addr`). Watchpoint `n` occupies indices `8n` to `8n+7`:

| Offset | Meaning |
|---|---|
| +0 | window low bound |
| +1 | window high bound |
| +2 | access-kind mask |
| +3 | client mask |
| +4 | accumulated clients |
| +5 | recorded address |
| +6 | recorded info |
| +7 | rearm |

The global registers are:

| Index | Meaning |
|---|---|
| 32 | interrupt enables |
| 33 | raw status |
| 34 | enabled status |
| 35 | acknowledge |

All other indices read as zero.

Top module: `acc_watch_unit`

## Requirements
- R1: After reset every register reads zero and `irq` is low; with all masks zero no access can hit.
- R2: An access hits a watchpoint only when low bound <= address <= high bound, both bounds included; a window whose low bound exceeds its high bound never hits.
- R3: The client mask has 14 bits, and bit c enables client ID c. An access from a client whose mask bit is clear, or whose ID is 14 or 15, never hits.
- R4: The access-kind mask uses bit 0 for reads (`mon_write`=0) and bit 1 for writes (`mon_write`=1); an access whose kind bit is clear never hits.
- R5: The first hit on an armed watchpoint is visible one cycle after the access. It records the address at +5 and sets the client set at +4 to only the hitting client's bit. At +6 it records the access kind one-hot in bits [1:0] (01 read, 10 write), the client ID in bits [7:4] and the size in bits [10:8]. It also sets that watchpoint's raw status bit (index 33, bit n).
- R6: While a record is held, further hits leave +5 and +6 unchanged and OR their client bit into +4; accesses that miss change nothing.
- R7: Any write to +7 clears +4, +5 and +6 and rearms the watchpoint without touching status; a hit in the same cycle as the rearm is recorded as a fresh first hit.
- R8: A raw status bit stays set until a write to index 35 with a one in that bit position; zero bits leave status alone, and a hit in the same cycle as its acknowledge leaves the bit set.
- R9: Index 34 reads raw status AND enables (index 32, bit n per watchpoint); `irq` is high exactly when index 34 is nonzero; enables never alter raw status.
- R10: Configuration registers read back what was written, truncated to their width (2-bit kind mask, 14-bit client mask, 4-bit enables); writes to recorded fields, status and unmapped indices are ignored, and +7, 35 and unmapped indices read zero.
- R11: The four watchpoints act independently, so one access may hit several of them, each judged on its own window and masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge |
| rst_n | input | 1 | asynchronous reset, active low |
| reg_wr_en | input | 1 | register write strobe |
| reg_addr | input | 6 | register word index for read and write |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data for `reg_addr`, combinational |
| mon_valid | input | 1 | an access is presented this cycle |
| mon_addr | input | 32 | access address |
| mon_client | input | 4 | requesting client ID |
| mon_write | input | 1 | 1 for a write access, 0 for a read |
| mon_size | input | 3 | access size code |
| irq | output | 1 | OR of enabled status bits |

## Verification
A wrong comparison or mask decode shows at index 33 one cycle after the offending access, as a status bit that is set or missing. A record that fails to freeze, or a client set that loses bits, appears on the next read of +4 to +6 after a second hit. A stale or lost status bit persists across acknowledges, and `irq` follows it combinationally, so a fault in the enable gating shows on the pin in the same cycle the enable register changes.

// File: rtl/acc_watch_pkg.sv
package acc_watch_pkg;

    // default geometry
    localparam int DEF_NUM_WP      = 4;
    localparam int DEF_ADDR_W      = 32;
    localparam int DEF_NUM_CLIENTS = 14;
    localparam int DEF_SIZE_W      = 3;
    localparam int DEF_DATA_W      = 32;

    // access kind is carried one-hot: bit 0 read, bit 1 write
    localparam int OP_W = 2;

    // per-watchpoint register window
    localparam int SLOT_REGS  = 8;
    localparam int SLOT_OFF_W = $clog2(SLOT_REGS);

    localparam logic [SLOT_OFF_W-1:0] OFF_LO_BOUND = 3'd0;
    localparam logic [SLOT_OFF_W-1:0] OFF_HI_BOUND = 3'd1;
    localparam logic [SLOT_OFF_W-1:0] OFF_OP_MASK  = 3'd2;
    localparam logic [SLOT_OFF_W-1:0] OFF_CL_MASK  = 3'd3;
    localparam logic [SLOT_OFF_W-1:0] OFF_REC_CL   = 3'd4;
    localparam logic [SLOT_OFF_W-1:0] OFF_REC_ADDR = 3'd5;
    localparam logic [SLOT_OFF_W-1:0] OFF_REC_INFO = 3'd6;
    localparam logic [SLOT_OFF_W-1:0] OFF_REARM    = 3'd7;

    // field positions inside the recorded-info word
    localparam int INFO_CL_LSB = 4;
    localparam int INFO_SZ_LSB = 8;

    // global registers follow the last watchpoint window
    localparam int GLB_REGS    = 4;
    localparam int GLB_EN_OFF  = 0;
    localparam int GLB_RAW_OFF = 1;
    localparam int GLB_MSK_OFF = 2;
    localparam int GLB_ACK_OFF = 3;

endpackage

// File: rtl/acc_watch_match.sv
module acc_watch_match
    import acc_watch_pkg::*;
#(
    parameter int ADDR_W      = DEF_ADDR_W,
    parameter int NUM_CLIENTS = DEF_NUM_CLIENTS,
    parameter int CID_W       = $clog2(NUM_CLIENTS)
)(
    input  logic [ADDR_W-1:0]      lo_bound,
    input  logic [ADDR_W-1:0]      hi_bound,
    input  logic [OP_W-1:0]        op_mask,
    input  logic [NUM_CLIENTS-1:0] cl_mask,
    input  logic                   mon_valid,
    input  logic [ADDR_W-1:0]      mon_addr,
    input  logic [CID_W-1:0]       mon_client,
    input  logic                   mon_write,
    output logic                   hit,
    output logic [NUM_CLIENTS-1:0] cl_onehot,
    output logic [OP_W-1:0]        op_onehot
);

    logic in_window;
    logic client_ok;
    logic kind_ok;

    // client ID to one-hot; IDs past the last client give all zeros
    always_comb begin
        for (int c = 0; c < NUM_CLIENTS; c++) begin
            cl_onehot[c] = (mon_client == CID_W'(c));
        end
    end

    assign op_onehot = mon_write ? 2'b10 : 2'b01;

    assign in_window = (mon_addr >= lo_bound) && (mon_addr <= hi_bound);
    assign client_ok = |(cl_onehot & cl_mask);
    assign kind_ok   = |(op_onehot & op_mask);
    assign hit       = mon_valid && in_window && client_ok && kind_ok;

endmodule

// File: rtl/acc_watch_slot.sv
module acc_watch_slot
    import acc_watch_pkg::*;
#(
    parameter int ADDR_W      = DEF_ADDR_W,
    parameter int NUM_CLIENTS = DEF_NUM_CLIENTS,
    parameter int CID_W       = $clog2(NUM_CLIENTS),
    parameter int SIZE_W      = DEF_SIZE_W,
    parameter int DATA_W      = DEF_DATA_W
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [SLOT_OFF_W-1:0] wr_off,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [SLOT_OFF_W-1:0] rd_off,
    output logic [DATA_W-1:0]     rd_data,
    input  logic                  mon_valid,
    input  logic [ADDR_W-1:0]     mon_addr,
    input  logic [CID_W-1:0]      mon_client,
    input  logic                  mon_write,
    input  logic [SIZE_W-1:0]     mon_size,
    output logic                  hit,
    output logic                  captured
);

    typedef struct packed {
        logic [ADDR_W-1:0]      lo_bound;
        logic [ADDR_W-1:0]      hi_bound;
        logic [OP_W-1:0]        op_mask;
        logic [NUM_CLIENTS-1:0] cl_mask;
        logic                   held;
        logic [NUM_CLIENTS-1:0] rec_cl;
        logic [ADDR_W-1:0]      rec_addr;
        logic [OP_W-1:0]        rec_op;
        logic [CID_W-1:0]       rec_first;
        logic [SIZE_W-1:0]      rec_size;
    } slot_state_t;

    slot_state_t s_d, s_q;

    logic [NUM_CLIENTS-1:0] cl_onehot;
    logic [OP_W-1:0]        op_onehot;
    logic                   rearm;

    acc_watch_match #(
        .ADDR_W      (ADDR_W),
        .NUM_CLIENTS (NUM_CLIENTS),
        .CID_W       (CID_W)
    ) u_match (
        .lo_bound   (s_q.lo_bound),
        .hi_bound   (s_q.hi_bound),
        .op_mask    (s_q.op_mask),
        .cl_mask    (s_q.cl_mask),
        .mon_valid  (mon_valid),
        .mon_addr   (mon_addr),
        .mon_client (mon_client),
        .mon_write  (mon_write),
        .hit        (hit),
        .cl_onehot  (cl_onehot),
        .op_onehot  (op_onehot)
    );

    assign rearm = wr_en && (wr_off == OFF_REARM);

    always_comb begin
        s_d = s_q;

        if (wr_en) begin
            case (wr_off)
                OFF_LO_BOUND: s_d.lo_bound = wr_data[ADDR_W-1:0];
                OFF_HI_BOUND: s_d.hi_bound = wr_data[ADDR_W-1:0];
                OFF_OP_MASK:  s_d.op_mask  = wr_data[OP_W-1:0];
                OFF_CL_MASK:  s_d.cl_mask  = wr_data[NUM_CLIENTS-1:0];
                default:      ;
            endcase
        end

        if (rearm) begin
            s_d.held      = 1'b0;
            s_d.rec_cl    = '0;
            s_d.rec_addr  = '0;
            s_d.rec_op    = '0;
            s_d.rec_first = '0;
            s_d.rec_size  = '0;
        end

        if (hit) begin
            if (!s_q.held || rearm) begin
                s_d.held      = 1'b1;
                s_d.rec_cl    = cl_onehot;
                s_d.rec_addr  = mon_addr;
                s_d.rec_op    = op_onehot;
                s_d.rec_first = mon_client;
                s_d.rec_size  = mon_size;
            end else begin
                s_d.rec_cl = s_q.rec_cl | cl_onehot;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // readback
    always_comb begin
        rd_data = '0;
        case (rd_off)
            OFF_LO_BOUND: rd_data[ADDR_W-1:0]      = s_q.lo_bound;
            OFF_HI_BOUND: rd_data[ADDR_W-1:0]      = s_q.hi_bound;
            OFF_OP_MASK:  rd_data[OP_W-1:0]        = s_q.op_mask;
            OFF_CL_MASK:  rd_data[NUM_CLIENTS-1:0] = s_q.cl_mask;
            OFF_REC_CL:   rd_data[NUM_CLIENTS-1:0] = s_q.rec_cl;
            OFF_REC_ADDR: rd_data[ADDR_W-1:0]      = s_q.rec_addr;
            OFF_REC_INFO: begin
                rd_data[OP_W-1:0]               = s_q.rec_op;
                rd_data[INFO_CL_LSB +: CID_W]   = s_q.rec_first;
                rd_data[INFO_SZ_LSB +: SIZE_W]  = s_q.rec_size;
            end
            default: rd_data = '0;
        endcase
    end

    assign captured = s_q.held;

endmodule

// File: rtl/acc_watch_status.sv
module acc_watch_status #(
    parameter int NUM_WP = 4
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_WP-1:0] hit,
    input  logic              en_we,
    input  logic [NUM_WP-1:0] en_wdata,
    input  logic [NUM_WP-1:0] ack_clr,
    output logic [NUM_WP-1:0] raw,
    output logic [NUM_WP-1:0] en,
    output logic [NUM_WP-1:0] masked,
    output logic              irq
);

    typedef struct packed {
        logic [NUM_WP-1:0] raw;
        logic [NUM_WP-1:0] en;
    } st_state_t;

    st_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (en_we) begin
            s_d.en = en_wdata;
        end
        // a new hit wins over an acknowledge in the same cycle
        s_d.raw = (s_q.raw & ~ack_clr) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign raw    = s_q.raw;
    assign en     = s_q.en;
    assign masked = s_q.raw & s_q.en;
    assign irq    = |masked;

endmodule

// File: rtl/acc_watch_unit.sv
module acc_watch_unit
    import acc_watch_pkg::*;
#(
    parameter int NUM_WP      = DEF_NUM_WP,
    parameter int ADDR_W      = DEF_ADDR_W,
    parameter int NUM_CLIENTS = DEF_NUM_CLIENTS,
    parameter int SIZE_W      = DEF_SIZE_W,
    parameter int DATA_W      = DEF_DATA_W,
    localparam int CID_W      = $clog2(NUM_CLIENTS),
    localparam int REG_AW     = $clog2(NUM_WP * SLOT_REGS + GLB_REGS)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              mon_valid,
    input  logic [ADDR_W-1:0] mon_addr,
    input  logic [CID_W-1:0]  mon_client,
    input  logic              mon_write,
    input  logic [SIZE_W-1:0] mon_size,
    output logic              irq
);

    localparam int IDX_W    = REG_AW - SLOT_OFF_W;
    localparam int GLB_BASE = NUM_WP * SLOT_REGS;

    localparam logic [REG_AW-1:0] A_EN  = REG_AW'(GLB_BASE + GLB_EN_OFF);
    localparam logic [REG_AW-1:0] A_RAW = REG_AW'(GLB_BASE + GLB_RAW_OFF);
    localparam logic [REG_AW-1:0] A_MSK = REG_AW'(GLB_BASE + GLB_MSK_OFF);
    localparam logic [REG_AW-1:0] A_ACK = REG_AW'(GLB_BASE + GLB_ACK_OFF);

    logic [NUM_WP-1:0] wp_sel;
    logic [NUM_WP-1:0] wp_hit;
    logic [NUM_WP-1:0] wp_captured;
    logic [DATA_W-1:0] wp_rd [NUM_WP];

    logic              en_we;
    logic [NUM_WP-1:0] st_ack;
    logic [NUM_WP-1:0] st_raw;
    logic [NUM_WP-1:0] st_en;
    logic [NUM_WP-1:0] st_masked;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_WP; gi++) begin : g_wp
            assign wp_sel[gi] = (reg_addr[REG_AW-1:SLOT_OFF_W] == IDX_W'(gi));

            acc_watch_slot #(
                .ADDR_W      (ADDR_W),
                .NUM_CLIENTS (NUM_CLIENTS),
                .CID_W       (CID_W),
                .SIZE_W      (SIZE_W),
                .DATA_W      (DATA_W)
            ) u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_en      (reg_wr_en && wp_sel[gi]),
                .wr_off     (reg_addr[SLOT_OFF_W-1:0]),
                .wr_data    (reg_wdata),
                .rd_off     (reg_addr[SLOT_OFF_W-1:0]),
                .rd_data    (wp_rd[gi]),
                .mon_valid  (mon_valid),
                .mon_addr   (mon_addr),
                .mon_client (mon_client),
                .mon_write  (mon_write),
                .mon_size   (mon_size),
                .hit        (wp_hit[gi]),
                .captured   (wp_captured[gi])
            );
        end
    endgenerate

    assign en_we  = reg_wr_en && (reg_addr == A_EN);
    assign st_ack = (reg_wr_en && (reg_addr == A_ACK)) ? reg_wdata[NUM_WP-1:0] : '0;

    acc_watch_status #(
        .NUM_WP (NUM_WP)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (wp_hit),
        .en_we    (en_we),
        .en_wdata (reg_wdata[NUM_WP-1:0]),
        .ack_clr  (st_ack),
        .raw      (st_raw),
        .en       (st_en),
        .masked   (st_masked),
        .irq      (irq)
    );

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_WP; i++) begin
            if (wp_sel[i]) begin
                reg_rdata = wp_rd[i];
            end
        end
        if (reg_addr == A_EN) begin
            reg_rdata[NUM_WP-1:0] = st_en;
        end
        if (reg_addr == A_RAW) begin
            reg_rdata[NUM_WP-1:0] = st_raw;
        end
        if (reg_addr == A_MSK) begin
            reg_rdata[NUM_WP-1:0] = st_masked;
        end
    end

endmodule

// File: rtl/acc_watch_chk.sv
module acc_watch_chk #(
    parameter int NUM_WP      = 4,
    parameter int NUM_CLIENTS = 14,
    parameter int CID_W       = 4
)(
    input logic              clk,
    input logic              rst_n,
    input logic              mon_valid,
    input logic [CID_W-1:0]  mon_client,
    input logic              irq,
    input logic [NUM_WP-1:0] hit,
    input logic [NUM_WP-1:0] captured,
    input logic [NUM_WP-1:0] raw,
    input logic [NUM_WP-1:0] en,
    input logic [NUM_WP-1:0] ack_clr
);

    // R3: client IDs beyond the last client never qualify
    p_bad_client_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_valid && (mon_client >= CID_W'(NUM_CLIENTS))) |-> (hit == '0));

    // R5: a hit leaves its status bit set on the next cycle
    p_hit_sets_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((raw & $past(hit)) == $past(hit)));

    // R6: after a hit the watchpoint holds a record
    p_hit_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((captured & $past(hit)) == $past(hit)));

    // R8: status bits only fall when acknowledged
    p_raw_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(raw) & ~$past(ack_clr) & ~raw) == '0));

    // R8: status bits only rise because of a hit
    p_raw_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw & ~$past(raw) & ~$past(hit)) == '0));

    // R9: interrupt line tracks enabled status
    p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((raw & en) != '0));

    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw & en) != '0) |-> irq);

endmodule

bind acc_watch_unit acc_watch_chk #(
    .NUM_WP      (NUM_WP),
    .NUM_CLIENTS (NUM_CLIENTS),
    .CID_W       (CID_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mon_valid  (mon_valid),
    .mon_client (mon_client),
    .irq        (irq),
    .hit        (wp_hit),
    .captured   (wp_captured),
    .raw        (st_raw),
    .en         (st_en),
    .ack_clr    (st_ack)
);

// File: tb/acc_watch_unit_bench.sv
`timescale 1ns/1ps
module acc_watch_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mon_valid = 1'b0;
    logic [31:0] mon_addr = '0;
    logic [3:0]  mon_client = '0;
    logic        mon_write = 1'b0;
    logic [2:0]  mon_size = '0;
    logic        irq;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    acc_watch_unit u_acc_watch_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr_en  (reg_wr_en),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .mon_valid  (mon_valid),
        .mon_addr   (mon_addr),
        .mon_client (mon_client),
        .mon_write  (mon_write),
        .mon_size   (mon_size),
        .irq        (irq)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [31:0] lo;
        logic [31:0] hi;
        logic [1:0]  opm;
        logic [13:0] clm;
        logic [31:0] addr;
        logic [3:0]  cl;
        logic        wr;
        logic        exp;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{4'd2, 32'h100, 32'h1FF, 2'b11, 14'h3FFF, 32'h100, 4'd0,  1'b0, 1'b1}, // R2 low edge
        '{4'd2, 32'h100, 32'h1FF, 2'b11, 14'h3FFF, 32'h1FF, 4'd0,  1'b1, 1'b1}, // R2 high edge
        '{4'd2, 32'h100, 32'h1FF, 2'b11, 14'h3FFF, 32'h0FF, 4'd1,  1'b0, 1'b0}, // R2 below
        '{4'd2, 32'h100, 32'h1FF, 2'b11, 14'h3FFF, 32'h200, 4'd1,  1'b0, 1'b0}, // R2 above
        '{4'd3, 32'h100, 32'h1FF, 2'b11, 14'h0004, 32'h150, 4'd2,  1'b0, 1'b1}, // R3 enabled client
        '{4'd3, 32'h100, 32'h1FF, 2'b11, 14'h0004, 32'h150, 4'd3,  1'b0, 1'b0}, // R3 other client
        '{4'd3, 32'h100, 32'h1FF, 2'b11, 14'h3FFF, 32'h150, 4'd14, 1'b0, 1'b0}, // R3 ID 14
        '{4'd4, 32'h100, 32'h1FF, 2'b01, 14'h3FFF, 32'h150, 4'd0,  1'b1, 1'b0}, // R4 write, reads only
        '{4'd4, 32'h100, 32'h1FF, 2'b01, 14'h3FFF, 32'h150, 4'd0,  1'b0, 1'b1}, // R4 read, reads only
        '{4'd4, 32'h100, 32'h1FF, 2'b10, 14'h3FFF, 32'h150, 4'd0,  1'b1, 1'b1}, // R4 write, writes only
        '{4'd4, 32'h100, 32'h1FF, 2'b00, 14'h3FFF, 32'h150, 4'd0,  1'b0, 1'b0}, // R4 empty mask
        '{4'd2, 32'h500, 32'h400, 2'b11, 14'h3FFF, 32'h480, 4'd0,  1'b0, 1'b0}  // R2 inverted window
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [5:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic do_access(input logic [31:0] a, input logic [3:0] c,
                             input logic w, input logic [2:0] s);
        @(negedge clk);
        mon_valid  = 1'b1;
        mon_addr   = a;
        mon_client = c;
        mon_write  = w;
        mon_size   = s;
        @(negedge clk);
        mon_valid  = 1'b0;
    endtask

    // register write and access presented in the same cycle
    task automatic write_with_access(input logic [5:0] ra, input logic [31:0] rd,
                                     input logic [31:0] a, input logic [3:0] c,
                                     input logic w, input logic [2:0] s);
        @(negedge clk);
        reg_wr_en  = 1'b1;
        reg_addr   = ra;
        reg_wdata  = rd;
        mon_valid  = 1'b1;
        mon_addr   = a;
        mon_client = c;
        mon_write  = w;
        mon_size   = s;
        @(negedge clk);
        reg_wr_en  = 1'b0;
        mon_valid  = 1'b0;
    endtask

    initial begin
        #1_600_000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd_check($sformatf("R1 slot0 reg%0d", a), 6'(a), 32'h0);
        end
        rd_check("R1 enables", 6'd32, 32'h0);
        rd_check("R1 raw", 6'd33, 32'h0);
        rd_check("R1 masked", 6'd34, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'h0);
        do_access(32'h0, 4'd0, 1'b0, 3'd0);
        rd_check("R1 no hit with zero masks", 6'd33, 32'h0);

        // R10: register map behaviour
        reg_write(6'd2, 32'hFFFF_FFFF);
        rd_check("R10 kind mask width", 6'd2, 32'h3);
        reg_write(6'd3, 32'hFFFF_FFFF);
        rd_check("R10 client mask width", 6'd3, 32'h3FFF);
        reg_write(6'd1, 32'hDEAD_BEEF);
        rd_check("R10 high bound", 6'd1, 32'hDEAD_BEEF);
        reg_write(6'd5, 32'h1234);
        rd_check("R10 recorded addr read-only", 6'd5, 32'h0);
        reg_write(6'd33, 32'hF);
        rd_check("R10 raw read-only", 6'd33, 32'h0);
        rd_check("R10 rearm reads zero", 6'd7, 32'h0);
        reg_write(6'd40, 32'hFFFF_FFFF);
        rd_check("R10 unmapped reads zero", 6'd40, 32'h0);
        reg_write(6'd32, 32'hFF);
        rd_check("R10 enable width", 6'd32, 32'hF);
        reg_write(6'd32, 32'h0);

        // table: window, client and kind qualification on watchpoint 0
        for (int v = 0; v < NVEC; v++) begin
            logic [31:0] d;
            reg_write(6'd0, VECS[v].lo);
            reg_write(6'd1, VECS[v].hi);
            reg_write(6'd2, {30'd0, VECS[v].opm});
            reg_write(6'd3, {18'd0, VECS[v].clm});
            reg_write(6'd7, 32'h0);
            reg_write(6'd35, 32'hF);
            do_access(VECS[v].addr, VECS[v].cl, VECS[v].wr, 3'd0);
            reg_addr = 6'd33;
            #1;
            d = reg_rdata;
            check($sformatf("R%0d vec%0d hit", VECS[v].req, v), {31'd0, d[0]}, {31'd0, VECS[v].exp});
            if (VECS[v].exp) begin
                rd_check($sformatf("R5 vec%0d addr", v), 6'd5, VECS[v].addr);
            end
        end
        reg_write(6'd35, 32'hF);

        // R5: full record on watchpoint 1
        reg_write(6'd8,  32'h1000);
        reg_write(6'd9,  32'h1FFF);
        reg_write(6'd10, 32'h3);
        reg_write(6'd11, 32'h3FFF);
        do_access(32'h1234, 4'd5, 1'b1, 3'd2);
        rd_check("R5 addr", 6'd13, 32'h1234);
        rd_check("R5 info", 6'd14, 32'h252);
        rd_check("R5 clients", 6'd12, 32'h20);
        rd_check("R5 raw", 6'd33, 32'h2);

        // R6: record frozen, clients accumulate
        do_access(32'h1100, 4'd9, 1'b0, 3'd1);
        rd_check("R6 addr frozen", 6'd13, 32'h1234);
        rd_check("R6 info frozen", 6'd14, 32'h252);
        rd_check("R6 clients OR", 6'd12, 32'h220);
        do_access(32'h2000, 4'd1, 1'b0, 3'd0);
        rd_check("R6 miss leaves clients", 6'd12, 32'h220);

        // R9: enable gating
        check("R9 irq disabled", {31'd0, irq}, 32'h0);
        rd_check("R9 masked disabled", 6'd34, 32'h0);
        reg_write(6'd32, 32'h2);
        check("R9 irq enabled", {31'd0, irq}, 32'h1);
        rd_check("R9 masked enabled", 6'd34, 32'h2);
        reg_write(6'd32, 32'hD);
        check("R9 irq off again", {31'd0, irq}, 32'h0);
        rd_check("R9 masked off", 6'd34, 32'h0);
        rd_check("R9 raw untouched", 6'd33, 32'h2);

        // R8: acknowledge
        reg_write(6'd35, 32'h1);
        rd_check("R8 other bit kept", 6'd33, 32'h2);
        reg_write(6'd35, 32'h2);
        rd_check("R8 bit cleared", 6'd33, 32'h0);
        reg_write(6'd32, 32'hF);
        check("R8 irq low after ack", {31'd0, irq}, 32'h0);
        write_with_access(6'd35, 32'h2, 32'h1010, 4'd0, 1'b0, 3'd0);
        rd_check("R8 hit beats ack", 6'd33, 32'h2);
        check("R8 irq with hit", {31'd0, irq}, 32'h1);
        rd_check("R6 clients still OR", 6'd12, 32'h221);

        // R7: rearm
        reg_write(6'd15, 32'h0);
        rd_check("R7 addr cleared", 6'd13, 32'h0);
        rd_check("R7 info cleared", 6'd14, 32'h0);
        rd_check("R7 clients cleared", 6'd12, 32'h0);
        rd_check("R7 status kept", 6'd33, 32'h2);
        do_access(32'h1500, 4'd3, 1'b0, 3'd4);
        rd_check("R7 fresh addr", 6'd13, 32'h1500);
        rd_check("R7 fresh info", 6'd14, 32'h431);
        rd_check("R7 fresh clients", 6'd12, 32'h8);
        write_with_access(6'd15, 32'h0, 32'h1600, 4'd7, 1'b1, 3'd1);
        rd_check("R7 same-cycle addr", 6'd13, 32'h1600);
        rd_check("R7 same-cycle info", 6'd14, 32'h172);
        rd_check("R7 same-cycle clients", 6'd12, 32'h80);

        // R11: independent watchpoints
        reg_write(6'd35, 32'hF);
        reg_write(6'd16, 32'h3000);
        reg_write(6'd17, 32'h3FFF);
        reg_write(6'd18, 32'h3);
        reg_write(6'd19, 32'h3FFF);
        reg_write(6'd24, 32'h3800);
        reg_write(6'd25, 32'h4800);
        reg_write(6'd26, 32'h1);
        reg_write(6'd27, 32'h3FFF);
        do_access(32'h3900, 4'd1, 1'b1, 3'd0);
        rd_check("R11 write hits one", 6'd33, 32'h4);
        do_access(32'h3900, 4'd1, 1'b0, 3'd0);
        rd_check("R11 read hits two", 6'd33, 32'hC);
        do_access(32'h4000, 4'd2, 1'b0, 3'd0);
        rd_check("R11 wp3 clients", 6'd28, 32'h6);
        rd_check("R11 wp2 clients", 6'd20, 32'h2);
        rd_check("R11 wp3 first addr", 6'd29, 32'h3900);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule